// File: doc/BRIEF.md
# Four-Input Hit Clusterer with Mean-Time Primitive

This block takes corrected hit timestamps from four independent upstream streams and buffers each stream in its own small queue. It merges the four queues into a single stream in ascending time order and collects consecutive hits that lie close together in time into events. For every closed event it emits one primitive: the mean of the member timestamps, rounded down, and the number of hits in the event.

Each input also has an idle flag. The upstream source raises it when it has nothing more to send for now. The merger only picks a hit once every input either has a hit waiting or is flagged idle. A late hit on a slow input therefore cannot be overtaken by a later one from another input. An event is measured against the time of its first hit and a programmable window. A hit beyond that window closes the event and opens the next one. An event with no further hits closes once it has been open for as many clock cycles as the window value. The mean is formed by a sequential divider, and the primitive waits at the output until the consumer accepts it.

Top module: `evt_grouper`

## Requirements
- R1: After reset `out_valid` is 0 and every `in_ready` bit is 1. An input whose queue holds `FIFO_DEPTH` (default 8) unread hits drives its `in_ready` bit to 0.
- R2: Hits are taken from the four queues in ascending time order, whichever inputs they arrived on. Among equal times the lowest input index goes first.
- R3: No hit is taken while any input has an empty queue and its `in_idle` bit is 0. In that situation no primitive appears.
- R4: A hit whose time minus the first time of the open event is at most `cfg_window` joins that event. The boundary value itself joins.
- R5: A hit whose time minus the event's first time exceeds `cfg_window` closes the open event. The same hit becomes the first hit of a new event.
- R6: `out_time` equals the sum of the member times divided by the member count, rounded down.
- R7: `out_count` equals the number of hits in the event, from 1 to 15.
- R8: An event closes when it reaches 15 hits. The next hit starts a new event, even if it lies inside the window.
- R9: An open event with no hit on offer closes once it has been open for at least `cfg_window` cycles, so the last event of a burst is still emitted.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_time` and `out_count` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_window | input | 40 | Grouping window in time units, also the idle-close limit in cycles |
| in_valid | input | 4 | Per-input hit valid |
| in_time | input | 4x40 | Per-input hit timestamp |
| in_idle | input | 4 | Per-input flag: no further hit is coming for now |
| in_ready | output | 4 | Per-input queue has space |
| out_valid | output | 1 | Primitive available |
| out_time | output | 40 | Mean time of the event |
| out_count | output | 4 | Number of hits in the event |
| out_ready | input | 1 | Consumer accepts the primitive |

## Verification
A wrong merge choice does not show up as a misordered hit. It shows up as a changed grouping: different counts and means in the primitives that follow, visible as soon as the affected event closes. A wrong event boundary, such as an off-by-one against the window or a missing close at 15 hits, changes the count and mean of two neighbouring primitives. A stuck open event shows up as a missing trailing primitive a window's worth of cycles plus the divider latency later. A faulty divider or output hold corrupts the very next primitive, or that primitive's value while the consumer stalls.

// File: rtl/evg_pkg.sv
package evg_pkg;

    localparam int EVG_NUM_IN  = 4;
    localparam int EVG_TIME_W  = 40;
    localparam int EVG_CNT_W   = 4;
    localparam int EVG_DEPTH   = 8;

    typedef enum logic [1:0] {
        DV_IDLE = 2'd0,
        DV_RUN  = 2'd1,
        DV_DONE = 2'd2
    } evg_div_state_e;

    typedef struct packed {
        logic [EVG_TIME_W-1:0] tstamp;
        logic [EVG_CNT_W-1:0]  hits;
    } evg_prim_t;

    function automatic int evg_max_hits(input int cnt_w);
        return (1 << cnt_w) - 1;
    endfunction

endpackage

// File: rtl/evg_fifo.sv
module evg_fifo #(
    parameter int DATA_W = 40,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              rd_pop,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     fill;
    logic              do_wr, do_rd;

    assign wr_ready = (fill != CW'(DEPTH));
    assign rd_valid = (fill != '0);
    assign rd_data  = mem[rd_ptr];
    assign do_wr    = wr_valid && wr_ready;
    assign do_rd    = rd_pop && rd_valid;

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_wr, do_rd})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    // R3
    pop_when_empty_chk: assert property (@(posedge clk) disable iff (rst)
        rd_pop |-> rd_valid);

endmodule

// File: rtl/evg_merge.sv
module evg_merge #(
    parameter int NUM_IN = 4,
    parameter int TIME_W = 40
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_IN-1:0]             head_valid,
    input  logic [NUM_IN-1:0][TIME_W-1:0] head_time,
    input  logic [NUM_IN-1:0]             src_idle,
    input  logic                          take,
    output logic                          hit_valid,
    output logic [TIME_W-1:0]             hit_time,
    output logic [NUM_IN-1:0]             pop
);
    localparam int IW = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

    logic              all_known;
    logic              any_head;
    logic [IW-1:0]     best_idx;
    logic [TIME_W-1:0] best_time;
    logic              best_found;

    assign all_known = &(head_valid | src_idle);
    assign any_head  = |head_valid;
    assign hit_valid = all_known && any_head;
    assign hit_time  = best_time;

    always_comb begin
        best_idx   = '0;
        best_time  = '0;
        best_found = 1'b0;
        for (int i = 0; i < NUM_IN; i++) begin
            if (head_valid[i] && (!best_found || head_time[i] < best_time)) begin
                best_idx   = IW'(i);
                best_time  = head_time[i];
                best_found = 1'b1;
            end
        end
    end

    always_comb begin
        pop = '0;
        if (hit_valid && take) pop[best_idx] = 1'b1;
    end

    // R2
    pop_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pop));

    generate
        for (genvar g = 0; g < NUM_IN; g++) begin : g_order
            // R2
            min_order_chk: assert property (@(posedge clk) disable iff (rst)
                (hit_valid && head_valid[g]) |-> (hit_time <= head_time[g]));
        end
    endgenerate

endmodule

// File: rtl/evg_cluster.sv
module evg_cluster #(
    parameter int TIME_W = 40,
    parameter int CNT_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [TIME_W-1:0]       window,
    input  logic                    hit_valid,
    input  logic [TIME_W-1:0]       hit_time,
    output logic                    take,
    input  logic                    div_ready,
    output logic                    close_fire,
    output logic [TIME_W+CNT_W-1:0] close_sum,
    output logic [CNT_W-1:0]        close_cnt
);
    import evg_pkg::*;

    localparam int SUM_W    = TIME_W + CNT_W;
    localparam int MAX_HITS = evg_max_hits(CNT_W);

    logic              open_q;
    logic [TIME_W-1:0] first_q;
    logic [SUM_W-1:0]  sum_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [TIME_W-1:0] age_q;

    logic [TIME_W-1:0] diff;
    logic              in_win, full, timed_out, need_close, join_hit, start_hit;

    assign diff       = hit_time - first_q;
    assign in_win     = (diff <= window);
    assign full       = (cnt_q == CNT_W'(MAX_HITS));
    assign timed_out  = (age_q >= window);
    assign need_close = full || (hit_valid && !in_win) || (!hit_valid && timed_out);
    assign close_fire = open_q && need_close && div_ready;
    assign join_hit   = open_q && !full && hit_valid && in_win;
    assign start_hit  = hit_valid && (!open_q || close_fire);
    assign take       = join_hit || start_hit;
    assign close_sum  = sum_q;
    assign close_cnt  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q  <= 1'b0;
            first_q <= '0;
            sum_q   <= '0;
            cnt_q   <= '0;
            age_q   <= '0;
        end else begin
            if (start_hit) begin
                open_q  <= 1'b1;
                first_q <= hit_time;
                sum_q   <= SUM_W'(hit_time);
                cnt_q   <= CNT_W'(1);
                age_q   <= '0;
            end else begin
                if (join_hit) begin
                    sum_q <= sum_q + SUM_W'(hit_time);
                    cnt_q <= cnt_q + 1'b1;
                end
                if (close_fire) begin
                    open_q <= 1'b0;
                    cnt_q  <= '0;
                end
                if (open_q && (age_q != '1)) age_q <= age_q + 1'b1;
            end
        end
    end

    // R7
    close_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        close_fire |-> (close_cnt != '0));

    // R8
    count_cap_chk: assert property (@(posedge clk) disable iff (rst)
        (open_q && full) |=> !(join_hit && $past(open_q)) || (cnt_q == CNT_W'(1)));

    // R4
    join_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        join_hit |-> (hit_time - first_q <= window));

endmodule

// File: rtl/evg_div.sv
module evg_div #(
    parameter int TIME_W = 40,
    parameter int CNT_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic [TIME_W+CNT_W-1:0] dividend,
    input  logic [CNT_W-1:0]        divisor,
    output logic                    ready,
    output logic                    res_valid,
    output logic [TIME_W-1:0]       res_time,
    output logic [CNT_W-1:0]        res_count,
    input  logic                    res_ready
);
    import evg_pkg::*;

    localparam int SUM_W = TIME_W + CNT_W;
    localparam int SW    = $clog2(SUM_W + 1);

    evg_div_state_e   state_q;
    logic [SUM_W-1:0] dvd_q, quo_q;
    logic [CNT_W-1:0] rem_q, dsr_q;
    logic [SW-1:0]    step_q;

    logic [CNT_W:0]   rem_sh;
    logic             qbit;
    logic [CNT_W:0]   rem_nx;

    assign ready     = (state_q == DV_IDLE);
    assign res_valid = (state_q == DV_DONE);
    assign res_time  = quo_q[TIME_W-1:0];
    assign res_count = dsr_q;

    always_comb begin
        rem_sh = {rem_q, dvd_q[SUM_W-1]};
        qbit   = (rem_sh >= {1'b0, dsr_q});
        rem_nx = qbit ? (rem_sh - {1'b0, dsr_q}) : rem_sh;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DV_IDLE;
            dvd_q   <= '0;
            quo_q   <= '0;
            rem_q   <= '0;
            dsr_q   <= '0;
            step_q  <= '0;
        end else begin
            case (state_q)
                DV_IDLE: if (start) begin
                    dvd_q   <= dividend;
                    dsr_q   <= divisor;
                    quo_q   <= '0;
                    rem_q   <= '0;
                    step_q  <= SW'(SUM_W - 1);
                    state_q <= DV_RUN;
                end
                DV_RUN: begin
                    dvd_q <= dvd_q << 1;
                    quo_q <= {quo_q[SUM_W-2:0], qbit};
                    rem_q <= rem_nx[CNT_W-1:0];
                    if (step_q == '0) state_q <= DV_DONE;
                    else              step_q  <= step_q - 1'b1;
                end
                DV_DONE: if (res_ready) state_q <= DV_IDLE;
                default: state_q <= DV_IDLE;
            endcase
        end
    end

    // R6
    mean_fits_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (quo_q[SUM_W-1:TIME_W] == '0));

    // R10
    hold_output_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_time) && $stable(res_count)));

    // R7
    count_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_count != '0));

endmodule

// File: rtl/evt_grouper.sv
module evt_grouper
    import evg_pkg::*;
#(
    parameter int NUM_IN     = EVG_NUM_IN,
    parameter int TIME_W     = EVG_TIME_W,
    parameter int CNT_W      = EVG_CNT_W,
    parameter int FIFO_DEPTH = EVG_DEPTH
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [TIME_W-1:0]             cfg_window,
    input  logic [NUM_IN-1:0]             in_valid,
    input  logic [NUM_IN-1:0][TIME_W-1:0] in_time,
    input  logic [NUM_IN-1:0]             in_idle,
    output logic [NUM_IN-1:0]             in_ready,
    output logic                          out_valid,
    output logic [TIME_W-1:0]             out_time,
    output logic [CNT_W-1:0]              out_count,
    input  logic                          out_ready
);
    localparam int SUM_W = TIME_W + CNT_W;

    logic [NUM_IN-1:0]             head_valid;
    logic [NUM_IN-1:0][TIME_W-1:0] head_time;
    logic [NUM_IN-1:0]             pop;
    logic                          hit_valid, take;
    logic [TIME_W-1:0]             hit_time;
    logic                          div_ready, close_fire;
    logic [SUM_W-1:0]              close_sum;
    logic [CNT_W-1:0]              close_cnt;

    generate
        for (genvar g = 0; g < NUM_IN; g++) begin : g_q
            evg_fifo #(.DATA_W(TIME_W), .DEPTH(FIFO_DEPTH)) u_fifo (
                .clk      (clk),
                .rst      (rst),
                .wr_valid (in_valid[g]),
                .wr_data  (in_time[g]),
                .wr_ready (in_ready[g]),
                .rd_pop   (pop[g]),
                .rd_valid (head_valid[g]),
                .rd_data  (head_time[g])
            );
        end
    endgenerate

    evg_merge #(.NUM_IN(NUM_IN), .TIME_W(TIME_W)) u_merge (
        .clk        (clk),
        .rst        (rst),
        .head_valid (head_valid),
        .head_time  (head_time),
        .src_idle   (in_idle),
        .take       (take),
        .hit_valid  (hit_valid),
        .hit_time   (hit_time),
        .pop        (pop)
    );

    evg_cluster #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_cluster (
        .clk        (clk),
        .rst        (rst),
        .window     (cfg_window),
        .hit_valid  (hit_valid),
        .hit_time   (hit_time),
        .take       (take),
        .div_ready  (div_ready),
        .close_fire (close_fire),
        .close_sum  (close_sum),
        .close_cnt  (close_cnt)
    );

    evg_div #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .start     (close_fire),
        .dividend  (close_sum),
        .divisor   (close_cnt),
        .ready     (div_ready),
        .res_valid (out_valid),
        .res_time  (out_time),
        .res_count (out_count),
        .res_ready (out_ready)
    );

    // R1
    full_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (&head_valid == 1'b0) || 1'b1 ? ((in_ready & ~head_valid) == (~head_valid)) : 1'b1);

endmodule

// File: tb/evt_grouper_test.sv
module evt_grouper_test;
    localparam int N  = 4;
    localparam int TW = 40;
    localparam int CW = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic [TW-1:0]     cfg_window;
    logic [N-1:0]      in_valid;
    logic [N-1:0][TW-1:0] in_time;
    logic [N-1:0]      in_idle;
    logic [N-1:0]      in_ready;
    logic              out_valid;
    logic [TW-1:0]     out_time;
    logic [CW-1:0]     out_count;
    logic              out_ready;

    int tests = 0;
    int fails = 0;
    int got_n = 0;
    logic [TW-1:0] got_time [0:63];
    logic [CW-1:0] got_cnt  [0:63];

    always #5 clk = ~clk;

    evt_grouper uut (
        .clk(clk), .rst(rst), .cfg_window(cfg_window),
        .in_valid(in_valid), .in_time(in_time), .in_idle(in_idle),
        .in_ready(in_ready), .out_valid(out_valid), .out_time(out_time),
        .out_count(out_count), .out_ready(out_ready)
    );

    always @(negedge clk) begin
        if (!rst && out_valid && out_ready && got_n < 64) begin
            got_time[got_n] = out_time;
            got_cnt[got_n]  = out_count;
            got_n = got_n + 1;
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input int idx, input logic [TW-1:0] t);
        @(negedge clk);
        while (!in_ready[idx]) @(negedge clk);
        in_valid[idx] = 1'b1;
        in_time[idx]  = t;
        @(negedge clk);
        in_valid[idx] = 1'b0;
    endtask

    task automatic wait_prims(input int target, input string req);
        int guard = 0;
        while (got_n < target && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        check(req, 64'(got_n), 64'(target));
    endtask

    task automatic check_prim(input int idx, input logic [TW-1:0] t, input int c, input string req);
        check({req, " time"}, 64'(got_time[idx]), 64'(t));
        check({req, " count"}, 64'(got_cnt[idx]), 64'(c));
    endtask

    task automatic no_extra(input int target, input string req);
        repeat (150) @(negedge clk);
        check(req, 64'(got_n), 64'(target));
    endtask

    task automatic t_reset;
        check("R1 reset out_valid", 64'(out_valid), 64'd0);
        check("R1 reset in_ready", 64'(in_ready), 64'hF);
    endtask

    // R4 R5 R6 R7 R9: basic grouping and trailing close
    task automatic t_basic;
        int b = got_n;
        cfg_window = 10;
        in_idle = '0;
        push(0, 100); push(1, 103); push(2, 105); push(3, 200);
        in_idle = '1;
        wait_prims(b + 2, "R9 trailing event emitted");
        check_prim(b, 102, 3, "R6 R7 R4 basic event");
        check_prim(b + 1, 200, 1, "R5 R9 lone event");
        no_extra(b + 2, "R5 no extra primitive");
    endtask

    // R2: cross-input ordering
    task automatic t_order;
        int b = got_n;
        cfg_window = 5;
        in_idle = '0;
        push(0, 50); push(0, 80); push(1, 52); push(2, 79); push(3, 51);
        in_idle = '1;
        wait_prims(b + 2, "R2 order events");
        check_prim(b, 51, 3, "R2 first sorted event");
        check_prim(b + 1, 79, 2, "R2 second sorted event");
    endtask

    // R4 R5: window boundary
    task automatic t_boundary;
        int b = got_n;
        cfg_window = 10;
        in_idle = '0;
        push(0, 1000); push(0, 1010); push(0, 1011);
        in_idle = '1;
        wait_prims(b + 2, "R4 boundary events");
        check_prim(b, 1005, 2, "R4 edge joins");
        check_prim(b + 1, 1011, 1, "R5 edge plus one starts new");
    endtask

    // R8: fifteen-hit cap
    task automatic t_cap;
        int b = got_n;
        cfg_window = 100;
        in_idle = '0;
        for (int i = 0; i < 8; i++) push(0, 40'(500 + i));
        for (int i = 0; i < 8; i++) push(1, 40'(508 + i));
        in_idle = '1;
        wait_prims(b + 2, "R8 cap events");
        check_prim(b, 507, 15, "R8 full event");
        check_prim(b + 1, 515, 1, "R8 sixteenth hit new event");
    endtask

    // R10: output hold under backpressure
    task automatic t_hold;
        int b = got_n;
        logic [TW-1:0] t0;
        int guard = 0;
        cfg_window = 10;
        out_ready = 1'b0;
        in_idle = '0;
        push(0, 3000);
        in_idle = '1;
        while (!out_valid && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        check("R10 primitive pending", 64'(out_valid), 64'd1);
        t0 = out_time;
        repeat (6) @(negedge clk);
        check("R10 valid held", 64'(out_valid), 64'd1);
        check("R10 time held", 64'(out_time), 64'(t0));
        check("R10 count held", 64'(out_count), 64'd1);
        out_ready = 1'b1;
        wait_prims(b + 1, "R10 released");
        check_prim(b, 3000, 1, "R10 value");
    endtask

    // R1 R3: full queue and wait-for-all
    task automatic t_fill;
        int b = got_n;
        cfg_window = 10;
        in_idle = '0;
        for (int i = 0; i < 8; i++) push(2, 40'(7000 + i));
        @(negedge clk);
        check("R1 full queue not ready", 64'(in_ready[2]), 64'd0);
        check("R1 other queue ready", 64'(in_ready[0]), 64'd1);
        repeat (80) @(negedge clk);
        check("R3 no primitive while waiting", 64'(got_n), 64'(b));
        in_idle = '1;
        wait_prims(b + 1, "R3 released");
        check_prim(b, 7003, 8, "R3 R6 filled event");
    endtask

    initial begin
        rst = 1'b1;
        cfg_window = 10;
        in_valid = '0;
        in_time = '0;
        in_idle = '0;
        out_ready = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_order();
        t_boundary();
        t_cap();
        t_hold();
        t_fill();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog all requirements actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule